// File: doc/BRIEF.md
# Level-Triggered GPIO Interrupt Channel Unit

This block turns the levels of four general-purpose input ports into interrupt requests. It has eight channels. Each channel selects one byte-wide group of port pins through a 4-bit group field, then tests one bit of that group. The bit it tests is the channel's own number, so channel 5 always tests bit 5 of its group. A 3-bit trigger code tells the channel whether a high or a low level on that pin raises a request. Every port pin first passes through a two-flop synchroniser. After that, each channel compares the pin against its trigger condition on every cycle.

A request stays pending until software writes a one to the matching bit of the acknowledge register. If the pin is still at its active level, the request returns on the following cycle. Two further request bits latch done flags from neighbouring peripherals.

A 10-bit mask selects which pending requests reach the masked view and the single combined interrupt output. The mask is written through two separate addresses: one for the eight channel bits and one for the two done-flag bits. Software can therefore update either part without disturbing the other.

Top module: `gpio_level_irq`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low. This covers the trigger codes (address 0), the group selects (address 1), the mask (addresses 2 and 6), the pending vector (address 4) and the masked view (address 5).
- R2: Trigger code 1 (bits [3n+2:3n] of address 0) sets pending bit n whenever the tested pin is 1.
- R3: Trigger code 2 sets pending bit n whenever the tested pin is 0.
- R4: The group select for channel n sits in bits [4n+3:4n] of address 1. A value g selects port g/4 (A=0, B=1, C=2, D=3) and, within that port, bits [8(g%4)+7 : 8(g%4)]. Channel n tests bit n of that byte. Groups 10 and 11 lie beyond the 16-bit port C and read as zero.
- R5: Trigger codes 0 and 3 to 7 never raise a request, whatever the pin level.
- R6: A write to address 3 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. The acknowledge wins over a new request in the same cycle. If the level is still active, the bit is set again one cycle later.
- R7: A pending bit stays set after its pin leaves the active level, until it is acknowledged.
- R8: Address 5 reads pending AND mask. `irq` is high exactly when that value is non-zero.
- R9: A write to address 2 changes only mask bits 7:0. A write to address 6 changes only mask bits 9:8, taken from data bits 9:8. Both addresses read back the full mask.
- R10: `done_in[k]` high at a clock edge sets pending bit 8+k. The bit is cleared through the acknowledge register like any other.
- R11: Suppose a pin changes between clock edges. Its pending bit is still clear after the second following edge and is set after the third: two synchroniser stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_a | input | 32 | Port A raw pin levels |
| port_b | input | 32 | Port B raw pin levels |
| port_c | input | 16 | Port C raw pin levels |
| port_d | input | 32 | Port D raw pin levels |
| done_in | input | 2 | Done flags from other peripherals |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt, OR of the masked requests |

## Verification
The bench uses the default parameters: eight channels, 8-bit groups, 4-bit group selects, port widths 32/32/16/32 and two done flags. With these values every one of the 16 group codes can be swept on one channel. That sweep includes the two codes that fall beyond the narrow port C. Holding a pin at its active level across an acknowledge exercises the one-cycle re-arm and the three-edge latency from pin to pending bit.

// File: rtl/gli_pkg.sv
// Package gli_pkg
// Shared constants for the GPIO level interrupt unit: trigger codes and
// register addresses. Assumes a 3-bit register address space.
package gli_pkg;
    localparam logic [2:0] TRIG_HIGH   = 3'd1;
    localparam logic [2:0] TRIG_LOW    = 3'd2;

    localparam logic [2:0] A_TRIG      = 3'd0;
    localparam logic [2:0] A_PSEL      = 3'd1;
    localparam logic [2:0] A_MASK_LO   = 3'd2;
    localparam logic [2:0] A_ACK       = 3'd3;
    localparam logic [2:0] A_RAW       = 3'd4;
    localparam logic [2:0] A_MASKED    = 3'd5;
    localparam logic [2:0] A_MASK_HI   = 3'd6;

    // Level comparison for one channel; unknown codes give no hit.
    function automatic logic level_hit(input logic [2:0] code, input logic pin);
        case (code)
            TRIG_HIGH: level_hit = pin;
            TRIG_LOW:  level_hit = ~pin;
            default:   level_hit = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gli_sync.sv
// Module gli_sync
// Two-flop synchroniser for a bus of independent asynchronous levels.
// Assumes each bit is sampled on its own; no bus coherency is implied.
module gli_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift raw levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gli_channel.sv
// Module gli_channel
// One interrupt channel. It selects a byte group from the padded pin bus,
// tests bit CH_IDX of that group and compares it with the trigger code.
// Assumes the pin bus holds at least 2**SEL_W groups.
module gli_channel
    import gli_pkg::*;
#(
    parameter int unsigned CH_IDX = 0,
    parameter int unsigned GRP_W  = 8,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned BUS_W  = GRP_W * (1 << SEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] pins_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [2:0]       trig_i,
    output logic             hit_o
);
    localparam int unsigned BIT = CH_IDX % GRP_W;

    logic [GRP_W-1:0] group;
    int unsigned      base;

    // Pick the selected byte group and evaluate the level condition.
    always_comb begin
        base  = int'(sel_i) * GRP_W;
        group = pins_i[base +: GRP_W];
        hit_o = level_hit(trig_i, group[BIT]);
    end

    // R5: codes other than high and low level never produce a hit
    a_r5_unimpl_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i != TRIG_HIGH && trig_i != TRIG_LOW) |-> !hit_o);
endmodule

// File: rtl/gli_req.sv
// Module gli_req
// Pending request register with write-one acknowledge, mask gating and
// the combined interrupt. Assumes acknowledge has priority over a new set.
module gli_req #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    logic [N-1:0] pend_q;

    // Latch requests; acknowledged bits clear for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | req_i) & ~ack_i;
    end

    // Gate pending bits by the mask and merge into one line.
    always_comb begin
        masked_o = pend_q & mask_i;
        irq_o    = |masked_o;
    end

    assign pend_o = pend_q;

    // R6: an acknowledged bit is clear on the next cycle
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_i) |=> ((pend_q & $past(ack_i)) == '0));
    // R7: a pending bit stays until acknowledged
    a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(ack_i)) & ~pend_q) == '0));
    // R2: a bit only becomes pending when a request was present
    a_r2_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(req_i)) == '0));
endmodule

// File: rtl/gpio_level_irq.sv
// Module gpio_level_irq
// Top of the GPIO level interrupt unit. It holds the configuration
// registers, synchronises the four ports, places them on a padded group
// bus and runs one channel per request line. Assumes every port width
// fits within one port span (GRP_W * groups per port).
module gpio_level_irq
    import gli_pkg::*;
#(
    parameter int unsigned N_CH   = 8,
    parameter int unsigned N_EXT  = 2,
    parameter int unsigned GRP_W  = 8,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned A_W    = 32,
    parameter int unsigned B_W    = 32,
    parameter int unsigned C_W    = 16,
    parameter int unsigned D_W    = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] port_a,
    input  logic [B_W-1:0] port_b,
    input  logic [C_W-1:0] port_c,
    input  logic [D_W-1:0] port_d,
    input  logic [N_EXT-1:0] done_in,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [2:0]     rd_addr,
    output logic [31:0]    rd_data,
    output logic           irq
);
    localparam int unsigned N_PORTS = 4;
    localparam int unsigned N_GRP   = 1 << SEL_W;
    localparam int unsigned SPAN    = GRP_W * (N_GRP / N_PORTS);
    localparam int unsigned BUS_W   = GRP_W * N_GRP;
    localparam int unsigned IN_W    = A_W + B_W + C_W + D_W;
    localparam int unsigned N_REQ   = N_CH + N_EXT;
    localparam int unsigned TRIG_W  = 3 * N_CH;
    localparam int unsigned PSEL_W  = SEL_W * N_CH;

    logic [TRIG_W-1:0] trig_q;
    logic [PSEL_W-1:0] psel_q;
    logic [N_REQ-1:0]  mask_q;
    logic [IN_W-1:0]   pins_sync;
    logic [BUS_W-1:0]  pin_bus;
    logic [N_CH-1:0]   ch_hit;
    logic [N_REQ-1:0]  req_vec;
    logic [N_REQ-1:0]  ack_vec;
    logic [N_REQ-1:0]  pend;
    logic [N_REQ-1:0]  masked;

    // Configuration and mask register writes; mask updated lane by lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            psel_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_TRIG:    trig_q <= wr_data[TRIG_W-1:0];
                A_PSEL:    psel_q <= wr_data[PSEL_W-1:0];
                A_MASK_LO: mask_q[N_CH-1:0] <= wr_data[N_CH-1:0];
                A_MASK_HI: mask_q[N_REQ-1:N_CH] <= wr_data[N_REQ-1:N_CH];
                default:   ;
            endcase
        end
    end

    // Write-one acknowledge pulse derived from the register port.
    always_comb begin
        ack_vec = '0;
        if (wr_en && wr_addr == A_ACK) ack_vec = wr_data[N_REQ-1:0];
    end

    gli_sync #(.W(IN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({port_d, port_c, port_b, port_a}),
        .sync_o  (pins_sync)
    );

    // Place each synchronised port in its own zero-padded span.
    always_comb begin
        pin_bus = '0;
        pin_bus[0*SPAN +: A_W] = pins_sync[0 +: A_W];
        pin_bus[1*SPAN +: B_W] = pins_sync[A_W +: B_W];
        pin_bus[2*SPAN +: C_W] = pins_sync[A_W+B_W +: C_W];
        pin_bus[3*SPAN +: D_W] = pins_sync[A_W+B_W+C_W +: D_W];
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        gli_channel #(
            .CH_IDX (ch),
            .GRP_W  (GRP_W),
            .SEL_W  (SEL_W),
            .BUS_W  (BUS_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins_i (pin_bus),
            .sel_i  (psel_q[ch*SEL_W +: SEL_W]),
            .trig_i (trig_q[ch*3 +: 3]),
            .hit_o  (ch_hit[ch])
        );
    end

    assign req_vec = {done_in, ch_hit};

    gli_req #(.N(N_REQ)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_vec),
        .ack_i    (ack_vec),
        .mask_i   (mask_q),
        .pend_o   (pend),
        .masked_o (masked),
        .irq_o    (irq)
    );

    // Combinational register read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_TRIG:              rd_data[TRIG_W-1:0] = trig_q;
            A_PSEL:              rd_data[PSEL_W-1:0] = psel_q;
            A_MASK_LO, A_MASK_HI: rd_data[N_REQ-1:0] = mask_q;
            A_RAW:               rd_data[N_REQ-1:0] = pend;
            A_MASKED:            rd_data[N_REQ-1:0] = masked;
            default:             rd_data = '0;
        endcase
    end

    // R9: a low-lane mask write keeps the done-flag mask bits
    a_r9_hi_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MASK_LO) |=>
            (mask_q[N_REQ-1:N_CH] == $past(mask_q[N_REQ-1:N_CH])));
    // R9: a high-lane mask write keeps the channel mask bits
    a_r9_lo_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MASK_HI) |=>
            (mask_q[N_CH-1:0] == $past(mask_q[N_CH-1:0])));
    // R8: the interrupt line is low whenever nothing was pending
    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);
endmodule

// File: tb/sim_gpio_level_irq.sv
module sim_gpio_level_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] port_a = '0;
    logic [31:0] port_b = '0;
    logic [15:0] port_c = '0;
    logic [31:0] port_d = '0;
    logic [1:0]  done_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_level_irq u0 (
        .clk(clk), .rst_n(rst_n),
        .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d),
        .done_in(done_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset addr %0d", a), v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sync_high();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h1 << 9);          // ch3 high level
        idle(4);
        wr(3'd3, 32'h3FF);
        port_a = 32'h8;                 // bit3 of group 0
        idle(1); rd(3'd4, v); chk("R11 after edge 1", v & 32'h8, 32'h0);
        idle(1); rd(3'd4, v); chk("R11 after edge 2", v & 32'h8, 32'h0);
        idle(1); rd(3'd4, v); chk("R2 R11 after edge 3", v & 32'h8, 32'h8);
        port_a = 32'h0;
        idle(5); rd(3'd4, v); chk("R7 held after pin drop", v & 32'h8, 32'h8);
        wr(3'd3, 32'h3F7);              // zero on bit3
        rd(3'd4, v); chk("R6 zero ack keeps bit", v & 32'h8, 32'h8);
        wr(3'd3, 32'h8);
        rd(3'd4, v); chk("R6 ack clears", v & 32'h8, 32'h0);
        idle(2); rd(3'd4, v); chk("R6 stays clear when inactive", v & 32'h8, 32'h0);
    endtask

    task automatic t_low();
        logic [31:0] v;
        port_b = 32'hFFFF_FFFF;
        wr(3'd1, 32'h6 << 20);          // ch5 group 6 = port B byte 2
        wr(3'd0, 32'h2 << 15);          // ch5 low level
        idle(4);
        wr(3'd3, 32'h3FF);
        idle(1); rd(3'd4, v); chk("R3 no request while high", v & 32'h20, 32'h0);
        port_b[5] = 1'b0;               // other group: must not trigger
        idle(5); rd(3'd4, v); chk("R4 wrong group ignored", v & 32'h20, 32'h0);
        port_b[21] = 1'b0;
        idle(4); rd(3'd4, v); chk("R3 low level sets", v & 32'h20, 32'h20);
        port_b = 32'h0;
        wr(3'd0, 32'h0);
        idle(4);
        wr(3'd3, 32'h3FF);
    endtask

    task automatic t_groups();
        logic [31:0] v;
        logic [31:0] e;
        wr(3'd0, 32'h1);                // ch0 high level
        for (int g = 0; g < 16; g++) begin
            port_a = '0; port_b = '0; port_c = '0; port_d = '0;
            wr(3'd1, 32'(g));
            idle(4);
            wr(3'd3, 32'h3FF);
            e = 32'h1;
            case (g / 4)
                0: port_a[8*(g%4)] = 1'b1;
                1: port_b[8*(g%4)] = 1'b1;
                2: if (g % 4 < 2) port_c[8*(g%4)] = 1'b1;
                   else begin port_c = 16'hFFFF; e = 32'h0; end
                default: port_d[8*(g%4)] = 1'b1;
            endcase
            idle(4);
            rd(3'd4, v);
            chk($sformatf("R4 group %0d", g), v & 32'h1, e);
        end
        port_a = '0; port_b = '0; port_c = '0; port_d = '0;
        idle(4);
        wr(3'd3, 32'h3FF);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2) continue;
            wr(3'd0, 32'(c) << 3);      // ch1, tests port_a[1]
            wr(3'd3, 32'h3FF);
            port_a = 32'h2;
            idle(4); rd(3'd4, v);
            chk($sformatf("R5 code %0d pin high", c), v, 32'h0);
            port_a = 32'h0;
            idle(4); rd(3'd4, v);
            chk($sformatf("R5 code %0d pin low", c), v, 32'h0);
        end
    endtask

    task automatic t_ack_level();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h1 << 6);           // ch2 high level
        port_a = 32'h4;
        idle(4);
        rd(3'd4, v); chk("R2 ch2 pending", v, 32'h4);
        wr(3'd3, 32'h4);
        rd(3'd4, v); chk("R6 ack wins in its cycle", v, 32'h0);
        idle(1);
        rd(3'd4, v); chk("R6 re-arm next cycle", v, 32'h4);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd2, 32'hFFFF_FF04);
        rd(3'd2, v); chk("R9 low lane write", v, 32'h004);
        rd(3'd5, v); chk("R8 masked view", v, 32'h4);
        chk("R8 irq high", {31'b0, irq}, 32'h1);
        wr(3'd6, 32'h0000_03FF);
        rd(3'd6, v); chk("R9 high lane write", v, 32'h304);
        wr(3'd2, 32'h0);
        rd(3'd2, v); chk("R9 high lane survives", v, 32'h300);
        rd(3'd5, v); chk("R8 masked off", v, 32'h0);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
        port_a = 32'h0;
        wr(3'd0, 32'h0);
        idle(4);
        wr(3'd3, 32'h3FF);
    endtask

    task automatic t_done();
        logic [31:0] v;
        wr(3'd6, 32'h100);
        done_in = 2'b01;
        idle(1);
        done_in = 2'b00;
        rd(3'd4, v); chk("R10 done flag 0 latched", v, 32'h100);
        idle(3);
        rd(3'd4, v); chk("R10 done flag held", v, 32'h100);
        chk("R8 irq from done flag", {31'b0, irq}, 32'h1);
        done_in = 2'b10;
        idle(1);
        done_in = 2'b00;
        rd(3'd5, v); chk("R8 unmasked done flag 1 hidden", v, 32'h100);
        wr(3'd3, 32'h300);
        rd(3'd4, v); chk("R10 done flags acked", v, 32'h0);
        chk("R8 irq after ack", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        idle(5);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_sync_high();
        t_low();
        t_groups();
        t_unimpl();
        t_ack_level();
        t_mask();
        t_done();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule